// File: doc/BRIEF.md
# Sliding-Window Packet Synchronizer

This block finds packet boundaries in a byte stream that carries no sync byte and no reserved framing bit. A receiver may start listening partway through a packet. Every packet has the same length: seven bytes. Alignment is therefore recovered by testing each candidate seven-byte window, and only the window that passes every validity test is accepted. A serial receiver sits in front of the block and delivers one byte per strobe. The block turns that stream into decoded destination, source, command and 24-bit data fields, with a one-cycle pulse marking each accepted packet.

The block holds up to six earlier bytes. When a byte arrives and six are already held, the six held bytes and the new byte form the candidate. If the candidate is valid, its fields are latched and the holding store is cleared. If it is not, the oldest byte is dropped and the newest one is kept, so every later byte offset is still tried. The window is judged in the same cycle that its last byte is strobed. The result appears one clock later.

Top module: `pkt_sync`

## Requirements
- R1: After reset, `pkt_valid` is 0, all field outputs are 0 and the holding store is empty, so a packet sent right after reset is recognised on its seventh byte.
- R2: The byte order of a packet is fixed: byte 0 holds destination XOR 0x55, byte 1 holds source XOR 0xAA, byte 2 holds the command, bytes 3 to 5 hold the data and byte 6 holds the CRC. On acceptance, `dst_addr` = byte0 ^ 0x55, `src_addr` = byte1 ^ 0xAA, `cmd` = byte2, and `payload` = {byte3, byte4, byte5}, so byte3 is the most significant.
- R3: A window is rejected if its decoded destination or decoded source is 40 or more. An address of 39 is accepted.
- R4: A window is rejected if its command is above the parameter `CMD_MAX`, which defaults to 31. A command of 31 is accepted and a command of 32 is rejected.
- R5: A window is rejected unless byte 6 equals the CRC-8 of bytes 0 to 5. The CRC uses polynomial 0x07 and an initial value of 0x00. It processes byte 0 first, MSB first, with no reflection and no final XOR.
- R6: No window is judged before seven bytes have been collected. The first six strobes after reset or after an accepted packet never produce a pulse.
- R7: After an accepted packet the store is emptied. Bytes from the accepted packet never take part in a later window.
- R8: When a window is rejected, the oldest byte is discarded and six bytes are kept, so every following strobe produces a new judgement. A valid packet that follows any number of stray bytes is found.
- R9: `pkt_valid` goes high for exactly one cycle, in the cycle after the clock edge that takes in the seventh byte of a valid window. The field outputs change only together with that pulse and are held at all other times.
- R10: Cycles without `rx_valid` change nothing, whatever value `rx_byte` carries in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | 8 | Incoming byte |
| rx_valid | input | 1 | Strobe marking `rx_byte` as a new byte, at most one per cycle |
| dst_addr | output | 8 | Decoded destination address of the last accepted packet |
| src_addr | output | 8 | Decoded source address of the last accepted packet |
| cmd | output | 8 | Command of the last accepted packet |
| payload | output | 24 | Data of the last accepted packet, first data byte in bits 23:16 |
| pkt_valid | output | 1 | One-cycle pulse when a packet is accepted |

## Verification
A wrong fill count or a wrong shift shows up as a missing pulse, an extra pulse, or a pulse on the wrong strobe. Such an error is visible within seven strobes, because that is how long it takes a wrongly held byte to leave or enter a judged window. The bench keeps its own model of the window, so after every strobe it knows whether a pulse is due and with which fields. A store that is not cleared after a packet is exposed on purpose: the bench sends a tail whose window would be valid only if the last byte of the previous packet were still held. A corrupted hold register shows in the idle cycles, when the fields must not move.

// File: rtl/pkt_sync_pkg.sv
package pkt_sync_pkg;

    typedef logic [7:0] byte_t;

    localparam int unsigned PKT_BYTES  = 7;
    localparam int unsigned HOLD_BYTES = PKT_BYTES - 1;
    localparam int unsigned DATA_BYTES = 3;
    localparam int unsigned DATA_W     = DATA_BYTES * 8;

    // One byte of CRC-8, MSB first, non-reflected
    function automatic byte_t crc8_byte(byte_t crc_in, byte_t data, byte_t poly);
        byte_t c;
        c = crc_in ^ data;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/psync_crc8.sv
module psync_crc8
    import pkt_sync_pkg::*;
#(
    parameter int unsigned NBYTES = 6,
    parameter logic [7:0]  POLY   = 8'h07,
    parameter logic [7:0]  INIT   = 8'h00
) (
    input  logic [NBYTES-1:0][7:0] msg_i,   // index 0 is processed first
    output logic [7:0]             crc_o
);

    byte_t stage [NBYTES+1];

    assign stage[0] = INIT;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign stage[i+1] = crc8_byte(stage[i], msg_i[i], POLY);
    end

    assign crc_o = stage[NBYTES];

endmodule

// File: rtl/psync_check.sv
module psync_check
    import pkt_sync_pkg::*;
#(
    parameter int unsigned ADDR_LIMIT = 40,
    parameter int unsigned CMD_MAX    = 31,
    parameter logic [7:0]  DST_KEY    = 8'h55,
    parameter logic [7:0]  SRC_KEY    = 8'hAA
) (
    input  logic [7:0] dst_raw,
    input  logic [7:0] src_raw,
    input  logic [7:0] cmd_raw,
    input  logic [7:0] crc_calc,
    input  logic [7:0] crc_rx,
    output logic [7:0] dst_dec,
    output logic [7:0] src_dec,
    output logic       frame_ok
);

    localparam logic [8:0] LIMIT_W = 9'(ADDR_LIMIT);
    localparam logic [8:0] CMAX_W  = 9'(CMD_MAX);

    logic dst_in_range, src_in_range, cmd_in_range, crc_match;

    always_comb begin
        dst_dec      = dst_raw ^ DST_KEY;
        src_dec      = src_raw ^ SRC_KEY;
        dst_in_range = {1'b0, dst_dec} < LIMIT_W;
        src_in_range = {1'b0, src_dec} < LIMIT_W;
        cmd_in_range = {1'b0, cmd_raw} <= CMAX_W;
        crc_match    = crc_calc == crc_rx;
        frame_ok     = dst_in_range && src_in_range && cmd_in_range && crc_match;
    end

endmodule

// File: rtl/pkt_sync.sv
module pkt_sync
    import pkt_sync_pkg::*;
#(
    parameter int unsigned ADDR_LIMIT = 40,
    parameter int unsigned CMD_MAX    = 31,
    parameter logic [7:0]  DST_KEY    = 8'h55,
    parameter logic [7:0]  SRC_KEY    = 8'hAA,
    parameter logic [7:0]  CRC_POLY   = 8'h07,
    parameter logic [7:0]  CRC_INIT   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic [7:0]        dst_addr,
    output logic [7:0]        src_addr,
    output logic [7:0]        cmd,
    output logic [DATA_W-1:0] payload,
    output logic              pkt_valid
);

    localparam int unsigned CW = $clog2(HOLD_BYTES + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_BYTES);

    typedef struct packed {
        logic [HOLD_BYTES-1:0][7:0] win;   // win[0] is the oldest byte
        logic [CW-1:0]              cnt;
        logic [7:0]                 dst;
        logic [7:0]                 src;
        logic [7:0]                 cmd;
        logic [DATA_W-1:0]          data;
        logic                       vld;
    } sync_st_t;

    sync_st_t st_q, st_d;

    logic [7:0] crc_calc;
    logic [7:0] dst_dec, src_dec;
    logic       frame_ok;

    psync_crc8 #(
        .NBYTES (HOLD_BYTES),
        .POLY   (CRC_POLY),
        .INIT   (CRC_INIT)
    ) u_crc (
        .msg_i  (st_q.win),
        .crc_o  (crc_calc)
    );

    psync_check #(
        .ADDR_LIMIT (ADDR_LIMIT),
        .CMD_MAX    (CMD_MAX),
        .DST_KEY    (DST_KEY),
        .SRC_KEY    (SRC_KEY)
    ) u_check (
        .dst_raw  (st_q.win[0]),
        .src_raw  (st_q.win[1]),
        .cmd_raw  (st_q.win[2]),
        .crc_calc (crc_calc),
        .crc_rx   (rx_byte),
        .dst_dec  (dst_dec),
        .src_dec  (src_dec),
        .frame_ok (frame_ok)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (rx_valid) begin
            if (st_q.cnt < FULL) begin
                for (int i = 0; i < HOLD_BYTES; i++) begin
                    if (st_q.cnt == CW'(i)) st_d.win[i] = rx_byte;
                end
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (frame_ok) begin
                st_d.dst  = dst_dec;
                st_d.src  = src_dec;
                st_d.cmd  = st_q.win[2];
                st_d.data = {st_q.win[3], st_q.win[4], st_q.win[5]};
                st_d.vld  = 1'b1;
                st_d.cnt  = '0;
            end else begin
                for (int i = 0; i < HOLD_BYTES - 1; i++) begin
                    st_d.win[i] = st_q.win[i+1];
                end
                st_d.win[HOLD_BYTES-1] = rx_byte;
                st_d.cnt = FULL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dst_addr  = st_q.dst;
    assign src_addr  = st_q.src;
    assign cmd       = st_q.cmd;
    assign payload   = st_q.data;
    assign pkt_valid = st_q.vld;

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> ($stable(dst_addr) && $stable(src_addr) && $stable(cmd) && $stable(payload)));

    // R9
    pulse_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> $past(rx_valid));

    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (({1'b0, dst_addr} < 9'(ADDR_LIMIT)) && ({1'b0, src_addr} < 9'(ADDR_LIMIT))));

    // R4
    cmd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> ({1'b0, cmd} <= 9'(CMD_MAX)));

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    // R6
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st_q.cnt < FULL) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1) && !pkt_valid);

    // R7
    empty_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> st_q.cnt == '0);

    // R8
    slide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st_q.cnt == FULL && !frame_ok) |=> (st_q.cnt == FULL) && !pkt_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(st_q.cnt) && $stable(st_q.win) && !pkt_valid);

endmodule

// File: tb/pkt_sync_test.sv
`timescale 1ns/1ps
module pkt_sync_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0;
    logic [7:0]  dst_addr, src_addr, cmd;
    logic [23:0] payload;
    logic        pkt_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference window model, built from the requirements
    logic [7:0] mw [7];
    int         mc = 0;

    always #2.5 clk = ~clk;

    pkt_sync uut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .dst_addr(dst_addr), .src_addr(src_addr), .cmd(cmd),
        .payload(payload), .pkt_valid(pkt_valid)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // bit-serial CRC-8, poly 0x07, init 0, MSB first (R5)
    function automatic logic [7:0] ref_crc(input logic [7:0] m [7]);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 6; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[7] ^ m[i][b];
                c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    task automatic make_pkt(input logic [7:0] d, input logic [7:0] s, input logic [7:0] c,
                            input logic [23:0] dat, output logic [7:0] pk [7]);
        pk[0] = d ^ 8'h55;
        pk[1] = s ^ 8'hAA;
        pk[2] = c;
        pk[3] = dat[23:16];
        pk[4] = dat[15:8];
        pk[5] = dat[7:0];
        pk[6] = ref_crc(pk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0;
        mc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // send one byte; model decides whether a pulse is due, then checks ports
    task automatic send_byte(input logic [7:0] b, input string tag);
        bit          exp_v = 1'b0;
        logic [7:0]  ed = 0, es = 0, ec = 0;
        logic [23:0] edat = 0;
        string       ptag;
        ptag = tag;
        if (mc < 6) begin
            mw[mc] = b;
            mc++;
            ptag = "R6";
        end else begin
            mw[6] = b;
            ed = mw[0] ^ 8'h55;
            es = mw[1] ^ 8'hAA;
            ec = mw[2];
            edat = {mw[3], mw[4], mw[5]};
            exp_v = (ed < 40) && (es < 40) && (ec <= 31) && (ref_crc(mw) == mw[6]);
            if (exp_v) mc = 0;
            else begin
                for (int i = 0; i < 6; i++) mw[i] = mw[i+1];
                mc = 6;
            end
        end
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = $urandom;
        chk(ptag, "pkt_valid", {31'b0, pkt_valid}, {31'b0, exp_v});
        if (exp_v) begin
            chk("R2", "dst_addr", {24'b0, dst_addr}, {24'b0, ed});
            chk("R2", "src_addr", {24'b0, src_addr}, {24'b0, es});
            chk("R2", "cmd", {24'b0, cmd}, {24'b0, ec});
            chk("R2", "payload", {8'b0, payload}, {8'b0, edat});
            @(negedge clk);
            chk("R9", "pulse width", {31'b0, pkt_valid}, 32'd0);
        end
    endtask

    task automatic send_pkt(input logic [7:0] pk [7], input string tag);
        for (int i = 0; i < 7; i++) send_byte(pk[i], tag);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "pkt_valid", {31'b0, pkt_valid}, 32'd0);
        chk("R1", "fields", {dst_addr, src_addr, cmd}, 32'd0);
        chk("R1", "payload", {8'b0, payload}, 32'd0);
    endtask

    task automatic t_basic();
        logic [7:0] pk [7];
        make_pkt(8'd5, 8'd7, 8'd3, 24'h123456, pk);
        send_pkt(pk, "R2");
        chk("R9", "after pkt", {31'b0, pkt_valid}, 32'd0);
        make_pkt(8'd0, 8'd0, 8'd0, 24'hFFFFFF, pk);
        send_pkt(pk, "R2");
    endtask

    task automatic t_idle();
        logic [7:0] pk [7];
        logic [31:0] hold_f;
        hold_f = {dst_addr, src_addr, cmd};
        for (int i = 0; i < 6; i++) begin
            rx_byte = $urandom;
            @(negedge clk);
            chk("R10", "idle pulse", {31'b0, pkt_valid}, 32'd0);
            chk("R9", "idle fields", {dst_addr, src_addr, cmd}, hold_f);
        end
        make_pkt(8'd12, 8'd34, 8'd17, 24'hA0B0C0, pk);
        for (int i = 0; i < 7; i++) begin
            send_byte(pk[i], "R10");
            if (i == 2) begin
                for (int k = 0; k < 4; k++) begin
                    rx_byte = 8'hFF;
                    @(negedge clk);
                end
            end
        end
        chk("R10", "dst after gaps", {24'b0, dst_addr}, 32'd12);
    endtask

    task automatic t_addr();
        logic [7:0] pk [7];
        make_pkt(8'd39, 8'd1, 8'd2, 24'h000102, pk);
        send_pkt(pk, "R3");
        chk("R3", "dst 39 accepted", {24'b0, dst_addr}, 32'd39);
        make_pkt(8'd2, 8'd39, 8'd2, 24'h000103, pk);
        send_pkt(pk, "R3");
        chk("R3", "src 39 accepted", {24'b0, src_addr}, 32'd39);
        make_pkt(8'd40, 8'd1, 8'd2, 24'h000104, pk);
        send_pkt(pk, "R3");
        make_pkt(8'd1, 8'd40, 8'd2, 24'h000105, pk);
        send_pkt(pk, "R3");
    endtask

    task automatic t_cmd();
        logic [7:0] pk [7];
        make_pkt(8'd3, 8'd4, 8'd31, 24'h0A0B0C, pk);
        send_pkt(pk, "R4");
        chk("R4", "cmd 31 accepted", {24'b0, cmd}, 32'd31);
        make_pkt(8'd3, 8'd4, 8'd32, 24'h0A0B0D, pk);
        send_pkt(pk, "R4");
        chk("R4", "cmd 32 kept old", {24'b0, cmd}, 32'd31);
    endtask

    task automatic t_crc();
        logic [7:0] pk [7];
        make_pkt(8'd9, 8'd10, 8'd11, 24'h445566, pk);
        pk[6] = pk[6] ^ 8'h01;
        send_pkt(pk, "R5");
        chk("R5", "bad crc dst unchanged", {24'b0, dst_addr}, 32'd3);
    endtask

    task automatic t_resync();
        logic [7:0] pk [7];
        do_reset();
        send_byte(8'h13, "R8");
        send_byte(8'hC7, "R8");
        send_byte(8'h2E, "R8");
        send_byte(8'h90, "R8");
        make_pkt(8'd21, 8'd22, 8'd23, 24'h778899, pk);
        send_pkt(pk, "R8");
        chk("R8", "resync payload", {8'b0, payload}, 32'h778899);
        // partial junk then reset: store must be empty again
        send_byte(8'h01, "R1");
        send_byte(8'h02, "R1");
        send_byte(8'h03, "R1");
        do_reset();
        make_pkt(8'd30, 8'd31, 8'd4, 24'h010203, pk);
        send_pkt(pk, "R1");
        chk("R1", "packet after reset", {24'b0, dst_addr}, 32'd30);
    endtask

    task automatic t_empty();
        logic [7:0] pa [7];
        logic [7:0] tail [7];
        int d;
        for (d = 0; d < 65536; d++) begin
            make_pkt(8'd6, 8'd8, 8'd1, 24'(d), pa);
            if ((pa[6] ^ 8'h55) < 8'd40) break;
        end
        send_pkt(pa, "R7");
        tail[0] = pa[6];
        tail[1] = 8'd3 ^ 8'hAA;
        tail[2] = 8'd5;
        tail[3] = 8'h11;
        tail[4] = 8'h22;
        tail[5] = 8'h33;
        tail[6] = ref_crc(tail);
        for (int i = 1; i < 7; i++) send_byte(tail[i], "R7");
        chk("R7", "no pulse from stale byte", {31'b0, pkt_valid}, 32'd0);
        chk("R7", "src unchanged", {24'b0, src_addr}, 32'd8);
        send_byte(8'h5A, "R8");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_idle();
        t_addr();
        t_cmd();
        t_crc();
        t_resync();
        t_empty();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): run incomplete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule